// File: doc/BRIEF.md
# Byte-Lane SEC-DED Protected SRAM

A synchronous model of a 16-bit-wide static memory in which each byte lane holds its own 13-bit protected codeword: 8 data bits plus 5 check bits. The check bits are 4 Hamming bits and 1 overall parity bit. Because the two lanes are coded separately, a write to one byte never needs the other byte to be read first. On a write, each enabled byte is encoded and stored. On a read, each enabled byte is decoded, single-bit faults are corrected, and two status flags report what the decoder found.

Access control follows an asynchronous-style pin set, sampled on the clock. Two chip enables of opposite polarity select the block. An active-low write enable chooses between writing and reading. An active-low output enable gates read data. Two active-low byte enables pick the lanes. When both byte enables are off, the block is idle even if it is selected. The three-state data bus is modelled as a separate input, a separate output and an output-valid flag. A test-only port flips chosen stored codeword bits so that faults can be injected.

Read data, the valid flag and the error flags are registered: they appear one clock after the read is presented. The depth is `2**AW` words, 64 by default; the full-size part would use AW = 19.

Top module: `bytelane_ecc_sram`

## Requirements
- R1: A write (selected, `weN`=0) stores each enabled byte. A later read (selected, `weN`=1, `oeN`=0) returns the stored bytes on `rdData` with `rdValid`=1, one clock after the read is sampled.
- R2: A write with only one byte enable low leaves the data and check bits of the other byte lane unchanged.
- R3: When `ce1N`=1 or `ce2`=0, no write takes effect and `rdValid` is 0 on the following cycle.
- R4: When `ubN`=1 and `lbN`=1, no write takes effect and `rdValid` is 0 on the following cycle, even if the block is selected.
- R5: A read with `oeN`=1 gives `rdValid`=0. In a valid read, the byte of a lane whose enable is high (`lbN` gates bits 7:0, `ubN` gates bits 15:8) reads as 0x00.
- R6: Stored codeword bit 0 is the overall parity. Bits 1, 2, 4 and 8 are the Hamming bits. Data bits d0..d7 sit at codeword bits 3, 5, 6, 7, 9, 10, 11, 12. If any one of the 13 bits is flipped, a read returns the original byte with `errCorr`=1 and `errUncorr`=0.
- R7: If two distinct bits of one lane's codeword are flipped, a read gives `errUncorr`=1 and `errCorr`=0 for that lane.
- R8: Each flag is the OR of the per-lane results over the lanes enabled in the read. Faults in a lane that is not read are not reported. Both flags are 0 in any cycle with `rdValid`=0.
- R9: When `injEn`=1, the stored codeword at `addr` in each lane selected by `injLane` (bit 0 = lower, bit 1 = upper) is XORed with `injMask`, where mask bit k flips codeword bit k. A write to the same lane in the same cycle takes precedence, and the written value is stored clean.
- R10: After reset, `rdValid`, `rdData`, `errCorr` and `errUncorr` are all 0. `rdData` is 0 whenever `rdValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset of the output registers |
| addr | input | AW | Word address |
| wrData | input | 16 | Write data |
| weN | input | 1 | Write enable, active low (1 = read) |
| oeN | input | 1 | Output enable, active low |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ubN | input | 1 | Upper byte enable, active low |
| lbN | input | 1 | Lower byte enable, active low |
| injEn | input | 1 | Test: apply fault mask this cycle |
| injLane | input | 2 | Test: lanes to corrupt (bit 0 lower, bit 1 upper) |
| injMask | input | 13 | Test: codeword bits to flip |
| rdData | output | 16 | Corrected read data |
| rdValid | output | 1 | Read data driven (stands in for the bus leaving high impedance) |
| errCorr | output | 1 | Single-bit fault detected and corrected |
| errUncorr | output | 1 | Double-bit fault detected, not corrected |

## Verification
The two decoder outcomes, correction and uncorrectable detection, can occur in the same read cycle because the two lanes decode in parallel. The bench provokes this by injecting a one-bit fault into the lower lane and a two-bit fault into the upper lane at one address, then reading the full word. It expects both flags high together and the corrected lower byte on the bus. It then reads each lane alone, to confirm that each flag comes from its own lane, and checks that both flags drop on the next idle cycle.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;

  localparam int LANES  = 2;
  localparam int BYTE_W = 8;
  localparam int CW_W   = 13;

  typedef struct packed {
    logic [LANES-1:0] wrEn;
    logic [LANES-1:0] rdEn;
    logic             rdOut;
    logic [LANES-1:0] injEn;
  } strobes_t;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              single;
    logic              double;
  } decode_t;

  // Hamming syndrome over codeword positions 1..12
  function automatic logic [3:0] hamSyndrome(input logic [CW_W-1:0] cw);
    logic [3:0] syn;
    syn = '0;
    for (int i = 1; i < CW_W; i++) begin
      for (int k = 0; k < 4; k++) begin
        if (((i >> k) & 1) == 1) syn[k] = syn[k] ^ cw[i];
      end
    end
    return syn;
  endfunction

  function automatic logic [CW_W-1:0] eccEncode(input logic [BYTE_W-1:0] d);
    logic [CW_W-1:0] cw;
    logic [3:0] p;
    cw = '0;
    cw[3]  = d[0];
    cw[5]  = d[1];
    cw[6]  = d[2];
    cw[7]  = d[3];
    cw[9]  = d[4];
    cw[10] = d[5];
    cw[11] = d[6];
    cw[12] = d[7];
    p = hamSyndrome(cw);
    cw[1] = p[0];
    cw[2] = p[1];
    cw[4] = p[2];
    cw[8] = p[3];
    cw[0] = ^cw[CW_W-1:1];
    return cw;
  endfunction

  function automatic decode_t eccDecode(input logic [CW_W-1:0] cw);
    decode_t res;
    logic [3:0] syn;
    logic parBad;
    logic [CW_W-1:0] fixed;
    syn    = hamSyndrome(cw);
    parBad = ^cw;
    fixed  = cw;
    res.single = parBad && (syn <= 4'd12);
    res.double = (!parBad && (syn != 4'd0)) || (parBad && (syn > 4'd12));
    if (parBad && (syn != 4'd0) && (syn <= 4'd12)) fixed[syn] = ~fixed[syn];
    res.data = {fixed[12], fixed[11], fixed[10], fixed[9],
                fixed[7], fixed[6], fixed[5], fixed[3]};
    return res;
  endfunction

endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import ecc_sram_pkg::*;
(
  input  logic     weN,
  input  logic     oeN,
  input  logic     ce1N,
  input  logic     ce2,
  input  logic     ubN,
  input  logic     lbN,
  input  logic     injEn,
  input  logic [LANES-1:0] injLane,
  output strobes_t strobes
);

  logic chipOn;
  logic [LANES-1:0] laneOn;

  assign chipOn = !ce1N && ce2;
  assign laneOn = {!ubN, !lbN};

  always_comb begin
    strobes       = '0;
    strobes.wrEn  = (chipOn && !weN) ? laneOn : '0;
    strobes.rdOut = chipOn && weN && !oeN && (laneOn != '0);
    strobes.rdEn  = strobes.rdOut ? laneOn : '0;
    strobes.injEn = injEn ? injLane : '0;
  end

endmodule

// File: rtl/sram_lane.sv
module sram_lane
  import ecc_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] wrByte,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              injEn,
  input  logic [CW_W-1:0]   injMask,
  output logic [BYTE_W-1:0] rdByte,
  output logic              corr,
  output logic              uncorr
);

  localparam int DEPTH = 1 << AW;

  logic [CW_W-1:0] store [DEPTH];
  decode_t dec;

  assign dec = eccDecode(store[addr]);

  always_ff @(posedge clk) begin
    if (wrEn) store[addr] <= eccEncode(wrByte);
    else if (injEn) store[addr] <= store[addr] ^ injMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdByte <= '0;
      corr   <= 1'b0;
      uncorr <= 1'b0;
    end else if (rdEn) begin
      rdByte <= dec.data;
      corr   <= dec.single;
      uncorr <= dec.double;
    end else begin
      rdByte <= '0;
      corr   <= 1'b0;
      uncorr <= 1'b0;
    end
  end

  // R6/R7: a lane never reports both outcomes at once
  a_r7_lane_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(corr && uncorr));

  // R5: an unread lane drives a zero byte and no flags on the next cycle
  a_r5_idle_lane_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> (rdByte == '0) && !corr && !uncorr);

endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import ecc_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*BYTE_W-1:0] wrData,
  input  logic [CW_W-1:0]         injMask,
  input  strobes_t                strobes,
  output logic [LANES*BYTE_W-1:0] rdData,
  output logic                    rdValid,
  output logic                    errCorr,
  output logic                    errUncorr
);

  logic [LANES-1:0] laneCorr;
  logic [LANES-1:0] laneUncorr;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    sram_lane #(.AW(AW)) lane_i (
      .clk    (clk),
      .rstN   (rstN),
      .addr   (addr),
      .wrByte (wrData[g*BYTE_W +: BYTE_W]),
      .wrEn   (strobes.wrEn[g]),
      .rdEn   (strobes.rdEn[g]),
      .injEn  (strobes.injEn[g]),
      .injMask(injMask),
      .rdByte (rdData[g*BYTE_W +: BYTE_W]),
      .corr   (laneCorr[g]),
      .uncorr (laneUncorr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= strobes.rdOut;
  end

  assign errCorr   = |laneCorr;
  assign errUncorr = |laneUncorr;

  // R10: data bus is quiet whenever it is not valid
  a_r10_data_zero_when_invalid: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == '0));

endmodule

// File: rtl/bytelane_ecc_sram.sv
module bytelane_ecc_sram
  import ecc_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wrData,
  input  logic          weN,
  input  logic          oeN,
  input  logic          ce1N,
  input  logic          ce2,
  input  logic          ubN,
  input  logic          lbN,
  input  logic          injEn,
  input  logic [1:0]    injLane,
  input  logic [12:0]   injMask,
  output logic [15:0]   rdData,
  output logic          rdValid,
  output logic          errCorr,
  output logic          errUncorr
);

  strobes_t strobes;

  sram_ctrl ctrl_i (
    .weN    (weN),
    .oeN    (oeN),
    .ce1N   (ce1N),
    .ce2    (ce2),
    .ubN    (ubN),
    .lbN    (lbN),
    .injEn  (injEn),
    .injLane(injLane),
    .strobes(strobes)
  );

  sram_datapath #(.AW(AW)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .addr     (addr),
    .wrData   (wrData),
    .injMask  (injMask),
    .strobes  (strobes),
    .rdData   (rdData),
    .rdValid  (rdValid),
    .errCorr  (errCorr),
    .errUncorr(errUncorr)
  );

  // R3: deselected cycle yields no valid data next cycle
  a_r3_deselect_no_read: assert property (@(posedge clk) disable iff (!rstN)
    (ce1N || !ce2) |=> !rdValid);

  // R4: both byte enables off yields no valid data next cycle
  a_r4_no_lane_no_read: assert property (@(posedge clk) disable iff (!rstN)
    (ubN && lbN) |=> !rdValid);

  // R5: output enable high or a write cycle gives no valid data
  a_r5_oe_gates_read: assert property (@(posedge clk) disable iff (!rstN)
    (oeN || !weN) |=> !rdValid);

  // R8: flags only accompany valid read data
  a_r8_flags_need_read: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (!errCorr && !errUncorr));

endmodule

// File: tb/bytelane_ecc_sram_tb_top.sv
module bytelane_ecc_sram_tb_top;

  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] addr;
  logic [15:0]   wrData;
  logic          weN, oeN, ce1N, ce2, ubN, lbN;
  logic          injEn;
  logic [1:0]    injLane;
  logic [12:0]   injMask;
  logic [15:0]   rdData;
  logic          rdValid, errCorr, errUncorr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bytelane_ecc_sram #(.AW(AW)) dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData),
    .weN(weN), .oeN(oeN), .ce1N(ce1N), .ce2(ce2), .ubN(ubN), .lbN(lbN),
    .injEn(injEn), .injLane(injLane), .injMask(injMask),
    .rdData(rdData), .rdValid(rdValid), .errCorr(errCorr), .errUncorr(errUncorr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    weN = 1'b1; oeN = 1'b1; ce1N = 1'b1; ce2 = 1'b0; ubN = 1'b1; lbN = 1'b1;
    injEn = 1'b0; injLane = 2'b00; injMask = '0; wrData = '0;
  endtask

  // present one access at negedge, let one posedge capture it, return at next negedge
  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [15:0] d,
                         input logic u, input logic l);
    addr = a; wrData = d; ce1N = 1'b0; ce2 = 1'b1; weN = 1'b0; ubN = u; lbN = l;
    cycle();
  endtask

  task automatic doRead(input logic [AW-1:0] a, input logic u, input logic l,
                        output logic [15:0] d, output logic v,
                        output logic c, output logic x);
    addr = a; ce1N = 1'b0; ce2 = 1'b1; weN = 1'b1; oeN = 1'b0; ubN = u; lbN = l;
    @(posedge clk);
    @(negedge clk);
    d = rdData; v = rdValid; c = errCorr; x = errUncorr;
    idle();
  endtask

  task automatic doInject(input logic [AW-1:0] a, input logic [1:0] lanes,
                          input logic [12:0] m);
    addr = a; injEn = 1'b1; injLane = lanes; injMask = m;
    cycle();
  endtask

  task automatic testReset();
    check("R10 rdValid after reset", {31'd0, rdValid}, 32'd0);
    check("R10 rdData after reset", {16'd0, rdData}, 32'd0);
    check("R10 flags after reset", {30'd0, errCorr, errUncorr}, 32'd0);
  endtask

  task automatic testWordRW();
    logic [15:0] d; logic v, c, x;
    logic [15:0] pats [4] = '{16'h0000, 16'hFFFF, 16'hA55A, 16'h1234};
    for (int i = 0; i < 4; i++) doWrite(AW'(i + 1), pats[i], 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      doRead(AW'(i + 1), 1'b0, 1'b0, d, v, c, x);
      check("R1 read data", {16'd0, d}, {16'd0, pats[i]});
      check("R1 read valid, clean", {29'd0, v, c, x}, 32'h4);
    end
  endtask

  task automatic testByteWrite();
    logic [15:0] d; logic v, c, x;
    doWrite(AW'(10), 16'hBEEF, 1'b0, 1'b0);
    doWrite(AW'(10), 16'h1177, 1'b1, 1'b0);   // lower lane only
    doRead(AW'(10), 1'b0, 1'b0, d, v, c, x);
    check("R2 lower write keeps upper", {16'd0, d}, 32'h0000BE77);
    check("R2 upper codeword intact", {30'd0, c, x}, 32'd0);
    doWrite(AW'(10), 16'h22CC, 1'b0, 1'b1);   // upper lane only
    doRead(AW'(10), 1'b0, 1'b0, d, v, c, x);
    check("R2 upper write keeps lower", {16'd0, d}, 32'h00002277);
  endtask

  task automatic testDeselect();
    logic [15:0] d; logic v, c, x;
    doWrite(AW'(12), 16'h5A5A, 1'b0, 1'b0);
    addr = AW'(12); wrData = 16'hFFFF; ce1N = 1'b1; ce2 = 1'b1; weN = 1'b0;
    ubN = 1'b0; lbN = 1'b0;
    cycle();
    addr = AW'(12); wrData = 16'h0F0F; ce1N = 1'b0; ce2 = 1'b0; weN = 1'b0;
    ubN = 1'b0; lbN = 1'b0;
    cycle();
    addr = AW'(12); ce1N = 1'b1; ce2 = 1'b1; weN = 1'b1; oeN = 1'b0;
    ubN = 1'b0; lbN = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R3 read while ce1N high", {31'd0, rdValid}, 32'd0);
    idle();
    doRead(AW'(12), 1'b0, 1'b0, d, v, c, x);
    check("R3 deselected writes ignored", {16'd0, d}, 32'h00005A5A);
  endtask

  task automatic testNoLane();
    logic [15:0] d; logic v, c, x;
    doWrite(AW'(13), 16'h3C3C, 1'b1, 1'b1);
    doWrite(AW'(14), 16'h6699, 1'b0, 1'b0);
    doWrite(AW'(14), 16'h0000, 1'b1, 1'b1);
    doRead(AW'(14), 1'b1, 1'b1, d, v, c, x);
    check("R4 read with no lane", {15'd0, v, d}, 32'd0);
    doRead(AW'(14), 1'b0, 1'b0, d, v, c, x);
    check("R4 idle write ignored", {16'd0, d}, 32'h00006699);
  endtask

  task automatic testOutputEnable();
    logic [15:0] d; logic v, c, x;
    doWrite(AW'(15), 16'hC3A5, 1'b0, 1'b0);
    addr = AW'(15); ce1N = 1'b0; ce2 = 1'b1; weN = 1'b1; oeN = 1'b1;
    ubN = 1'b0; lbN = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R5 oeN high gives no data", {15'd0, rdValid, rdData}, 32'd0);
    idle();
    doRead(AW'(15), 1'b1, 1'b0, d, v, c, x);
    check("R5 lower-only read", {15'd0, v, d}, 32'h000100A5);
    doRead(AW'(15), 1'b0, 1'b1, d, v, c, x);
    check("R5 upper-only read", {15'd0, v, d}, 32'h0001C300);
  endtask

  task automatic testSingle();
    logic [15:0] d; logic v, c, x;
    for (int b = 0; b < 13; b++) begin
      doWrite(AW'(20), 16'h9D62, 1'b0, 1'b0);
      doInject(AW'(20), 2'b01, 13'(1) << b);
      doRead(AW'(20), 1'b0, 1'b0, d, v, c, x);
      check($sformatf("R6 lower bit %0d corrected data", b), {16'd0, d}, 32'h00009D62);
      check($sformatf("R6 lower bit %0d flags", b), {30'd0, c, x}, 32'h2);
    end
    doWrite(AW'(21), 16'h4E00, 1'b0, 1'b0);
    doInject(AW'(21), 2'b10, 13'h0200);
    doRead(AW'(21), 1'b0, 1'b0, d, v, c, x);
    check("R6 upper data bit corrected", {14'd0, c, x, d}, 32'h00024E00);
  endtask

  task automatic testDouble();
    logic [15:0] d; logic v, c, x;
    logic [12:0] masks [4] = '{13'h0003, 13'h0088, 13'h1001, 13'h0600};
    for (int i = 0; i < 4; i++) begin
      doWrite(AW'(22), 16'h7E81, 1'b0, 1'b0);
      doInject(AW'(22), 2'b01, masks[i]);
      doRead(AW'(22), 1'b0, 1'b0, d, v, c, x);
      check($sformatf("R7 double mask %h flags", masks[i]), {30'd0, c, x}, 32'h1);
    end
  endtask

  // both decoder outcomes in one read cycle
  task automatic testBothFlags();
    logic [15:0] d; logic v, c, x;
    doWrite(AW'(30), 16'hD00D, 1'b0, 1'b0);
    doInject(AW'(30), 2'b01, 13'h0020);   // lower: single
    doInject(AW'(30), 2'b10, 13'h0104);   // upper: double
    doRead(AW'(30), 1'b0, 1'b0, d, v, c, x);
    check("R8 both flags same cycle", {30'd0, c, x}, 32'h3);
    check("R8 lower corrected alongside", {24'd0, d[7:0]}, 32'h0D);
    doRead(AW'(30), 1'b1, 1'b0, d, v, c, x);
    check("R8 lower-only: corr only", {30'd0, c, x}, 32'h2);
    doRead(AW'(30), 1'b0, 1'b1, d, v, c, x);
    check("R8 upper-only: uncorr only", {30'd0, c, x}, 32'h1);
    @(posedge clk); @(negedge clk);
    check("R8 flags clear when idle", {29'd0, rdValid, errCorr, errUncorr}, 32'd0);
  endtask

  task automatic testInjectVsWrite();
    logic [15:0] d; logic v, c, x;
    doWrite(AW'(31), 16'h1111, 1'b0, 1'b0);
    addr = AW'(31); wrData = 16'h2A2A; ce1N = 1'b0; ce2 = 1'b1; weN = 1'b0;
    ubN = 1'b0; lbN = 1'b0; injEn = 1'b1; injLane = 2'b11; injMask = 13'h0011;
    cycle();
    doRead(AW'(31), 1'b0, 1'b0, d, v, c, x);
    check("R9 write beats inject data", {16'd0, d}, 32'h00002A2A);
    check("R9 write beats inject flags", {30'd0, c, x}, 32'd0);
    doInject(AW'(31), 2'b10, 13'h0003);
    doRead(AW'(31), 1'b1, 1'b0, d, v, c, x);
    check("R9 unselected lane not corrupted", {30'd0, c, x}, 32'd0);
  endtask

  initial begin
    idle();
    addr = '0;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testWordRW();
    testByteWrite();
    testDeselect();
    testNoLane();
    testOutputEnable();
    testSingle();
    testDouble();
    testBothFlags();
    testInjectVsWrite();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule